// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block is the per-core monitor behind 32-bit load-exclusive / store-exclusive sequences. A core issues one of four operations: reserve-and-load, conditional store, drop the reservation, or swap the status flag. A load-exclusive reads a word and remembers both its address and the value it saw. A later store-exclusive to the same address is carried out as one indivisible compare-and-swap on the memory port. Memory takes the new word only if it still holds the remembered value, so a write by any other agent in between makes the store fail.

The pass/fail outcome of each store-exclusive is kept in a status flag at bit 8 of a 9-bit atomic-control register. Software reads that flag back with the swap operation. The low six bits of the same register hold three 2-bit permission fields, one for each cache attribute. Every exclusive access is checked against the field for the page's attribute, and a forbidden access ends with an exception cause instead of a memory access. Address translation happens outside the block: the page's cache attribute arrives with each request.

Requests are one-cycle strobes accepted only while the block is idle. Each request is answered by exactly one `op_done` pulse carrying the result and any exception cause.

Top module: `excl_monitor`

## Requirements
- R1: After reset, the reservation address is all ones, the status flag (control bit 8) is 0, and the control register holds 0x028. A store-exclusive to any aligned address therefore fails, with status 0 and no memory request.
- R2: A load-exclusive (op_kind 0) to an aligned address issues one read (mem_cas=0), returns the word in op_rdata and records the address and the word. op_done pulses in the cycle after the memory acknowledges.
- R3: A store-exclusive (op_kind 1) whose address differs from the reservation makes no memory request, sets the status flag to 0 and completes in the cycle after acceptance.
- R4: A store-exclusive whose address equals the reservation issues one compare-and-swap (mem_cas=1, mem_cmp = recorded value, mem_wdata = new word). Success is 1 exactly when the old word returned by memory equals the recorded value, and memory changes only then.
- R5: After any store-exclusive whose address matched, the reservation is all ones again, whether the swap succeeded or not.
- R6: Every completed store-exclusive writes its success into the status flag and returns the flag's previous value in op_rdata bit 0, with the upper bits 0.
- R7: The swap operation (op_kind 3) returns the current status flag in op_rdata bit 0 and, in the same step, replaces the flag with op_wdata bit 0.
- R8: The permission field is chosen by op_attr: control bits [1:0] for bypass (0), [3:2] for write-through (1), [5:4] for write-back (2). A field of 0 ends the access with op_exc=1 and op_cause=3.
- R9: op_attr 3 (isolate) ends an exclusive access with op_cause=2. With HAS_DCACHE=0 the attribute is ignored and the bypass field always decides.
- R10: An exclusive access whose address has either of its two low bits set ends with op_cause=1. This alignment check comes before the reservation and permission checks. Any exception suppresses the memory request and leaves the reservation and the status flag unchanged.
- R11: The clear operation (op_kind 2) sets the reservation to all ones without touching memory.
- R12: With the control register at 0x29 and the reservation cleared, a store-exclusive of 1 to a word holding 3 gives status 0 and leaves 3. A load-exclusive followed by a store-exclusive of 2 then gives status 1 and leaves 2.
- R13: The memory request holds its address, kind, compare value and write data stable until mem_ready, and exactly one acknowledge completes it.
- R14: ctl_we loads the whole control register from ctl_wdata and takes priority over a status-flag update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | CTL_W | Control register write value |
| op_valid | input | 1 | One-cycle request strobe, taken only when idle |
| op_kind | input | 2 | 0 load-ex, 1 store-ex, 2 clear, 3 swap status |
| op_addr | input | AW | Byte address of the exclusive access |
| op_wdata | input | DW | Store data, or new flag in bit 0 for the swap |
| op_attr | input | 2 | Page cache attribute: 0 bypass, 1 write-through, 2 write-back, 3 isolate |
| op_done | output | 1 | Completion pulse |
| op_rdata | output | DW | Loaded word or previous status flag |
| op_exc | output | 1 | Operation ended with an exception |
| op_cause | output | 2 | 0 none, 1 misaligned, 2 load/store error, 3 exclusive error |
| mem_req | output | 1 | Memory request valid |
| mem_cas | output | 1 | 1 compare-and-swap, 0 read |
| mem_addr | output | AW | Memory word address |
| mem_cmp | output | DW | Compare value of the swap |
| mem_wdata | output | DW | Value written if the compare holds |
| mem_ready | input | 1 | Memory acknowledge |
| mem_rdata | input | DW | Word held before the access |

## Verification
The bench changes memory between a load-exclusive and its store. A design that compared addresses only, and did not swap against the recorded value, would report success and overwrite the other agent's data. It issues a second store-exclusive after both a passing and a failing swap, so a design that kept the reservation would issue a second memory request. The permission sweep covers every field value under every attribute, including isolate and a variant with no data cache, so a design that picked the wrong field or the wrong cause shows up at once. Misaligned and denied accesses are followed by a store to the previously reserved address, which must still succeed and so shows that the reservation was left untouched.

// File: rtl/excl_pkg.sv
package excl_pkg;

  typedef enum logic [1:0] {
    OP_LOADEX  = 2'd0,
    OP_STOREEX = 2'd1,
    OP_CLEAR   = 2'd2,
    OP_GETST   = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    ATTR_BYPASS = 2'd0,
    ATTR_WTHRU  = 2'd1,
    ATTR_WBACK  = 2'd2,
    ATTR_ISOL   = 2'd3
  } cache_attr_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_ALIGN = 2'd1,
    CAUSE_LDST  = 2'd2,
    CAUSE_EXCL  = 2'd3
  } exc_cause_e;

  // Select the 2-bit permission field for an attribute and grade it.
  function automatic exc_cause_e perm_cause(input logic [5:0] fields,
                                            input logic [1:0] attr,
                                            input bit         has_dcache);
    logic [1:0] eff;
    logic [1:0] fld;
    eff = has_dcache ? attr : ATTR_BYPASS;
    fld = 2'b00;
    case (cache_attr_e'(eff))
      ATTR_BYPASS: fld = fields[1:0];
      ATTR_WTHRU:  fld = fields[3:2];
      ATTR_WBACK:  fld = fields[5:4];
      default:     return CAUSE_LDST;
    endcase
    return (fld == 2'b00) ? CAUSE_EXCL : CAUSE_NONE;
  endfunction

endpackage

// File: rtl/excl_perm_check.sv
module excl_perm_check
  import excl_pkg::*;
#(
  parameter bit HAS_DCACHE = 1'b1
) (
  input  logic [5:0] fields,
  input  logic [1:0] attr,
  output logic [1:0] cause
);
  always_comb cause = perm_cause(fields, attr, HAS_DCACHE);

  always_comb begin
    if (!HAS_DCACHE) begin
      a_nc_bypass_r9: assert (cause == ((fields[1:0] == 2'b00) ? CAUSE_EXCL : CAUSE_NONE))
        else $error("no-cache variant did not use the bypass field");
    end
  end
endmodule

// File: rtl/excl_reservation.sv
module excl_reservation #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  logic [DW-1:0] set_val,
  input  logic          clr_en,
  output logic [AW-1:0] resv_addr,
  output logic [DW-1:0] resv_val
);
  localparam logic [AW-1:0] NO_RESV = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_addr <= NO_RESV;
      resv_val  <= '0;
    end else if (set_en) begin
      resv_addr <= set_addr;
      resv_val  <= set_val;
    end else if (clr_en) begin
      resv_addr <= NO_RESV;
    end
  end

  p_set_clr_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en))
    else $error("reservation set and cleared together");

  p_clear_takes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> resv_addr == NO_RESV)
    else $error("clear did not drop the reservation");
endmodule

// File: rtl/excl_ctl_reg.sv
module excl_ctl_reg #(
  parameter int              CTL_W     = 9,
  parameter int              FLAG_BIT  = 8,
  parameter logic [CTL_W-1:0] CTL_RESET = 9'h028
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             flag_we,
  input  logic             flag_in,
  output logic [CTL_W-1:0] ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl_q <= CTL_RESET;
    else if (we)      ctl_q <= wdata;
    else if (flag_we) ctl_q[FLAG_BIT] <= flag_in;
  end

  p_flag_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !we) |=> ctl_q[5:0] == $past(ctl_q[5:0]))
    else $error("flag update disturbed permission fields");

  p_write_wins_r14: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ctl_q == $past(wdata))
    else $error("control write lost");
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int               AW         = 32,
  parameter int               DW         = 32,
  parameter int               CTL_W      = 9,
  parameter int               FLAG_BIT   = 8,
  parameter logic [CTL_W-1:0] CTL_RESET  = 9'h028,
  parameter bit               HAS_DCACHE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             op_valid,
  input  logic [1:0]       op_kind,
  input  logic [AW-1:0]    op_addr,
  input  logic [DW-1:0]    op_wdata,
  input  logic [1:0]       op_attr,
  output logic             op_done,
  output logic [DW-1:0]    op_rdata,
  output logic             op_exc,
  output logic [1:0]       op_cause,
  output logic             mem_req,
  output logic             mem_cas,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_cmp,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ready,
  input  logic [DW-1:0]    mem_rdata
);
  localparam int ALB = $clog2(DW / 8);

  typedef enum logic [1:0] {S_IDLE, S_MEM, S_DONE} st_e;

  st_e             st_q, st_d;
  op_kind_e        kind_q, kind_in;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic            done_q, exc_q;
  logic [1:0]      cause_q;
  logic [DW-1:0]   rdata_q;

  logic [AW-1:0]   resv_addr;
  logic [DW-1:0]   resv_val;
  logic            resv_set, resv_clr;
  logic [CTL_W-1:0] ctl_q;
  logic            flag_we, flag_in, flag_now;
  logic [1:0]      perm;

  logic            fin, fin_exc, cap;
  logic [1:0]      fin_cause;
  logic [DW-1:0]   fin_rdata;

  // Named events for the assertions.
  logic accept, misal, resv_hit, mem_ack, cas_ack, cas_pass;

  assign kind_in  = op_kind_e'(op_kind);
  assign flag_now = ctl_q[FLAG_BIT];
  assign accept   = (st_q == S_IDLE) && op_valid;
  assign misal    = |op_addr[ALB-1:0];
  assign resv_hit = (op_addr == resv_addr);
  assign mem_ack  = (st_q == S_MEM) && mem_ready;
  assign cas_ack  = mem_ack && (kind_q == OP_STOREEX);
  assign cas_pass = (mem_rdata == resv_val);

  excl_perm_check #(.HAS_DCACHE(HAS_DCACHE)) u_perm (
    .fields (ctl_q[5:0]),
    .attr   (op_attr),
    .cause  (perm)
  );

  excl_reservation #(.AW(AW), .DW(DW)) u_resv (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (resv_set),
    .set_addr  (addr_q),
    .set_val   (mem_rdata),
    .clr_en    (resv_clr),
    .resv_addr (resv_addr),
    .resv_val  (resv_val)
  );

  excl_ctl_reg #(.CTL_W(CTL_W), .FLAG_BIT(FLAG_BIT), .CTL_RESET(CTL_RESET)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (ctl_we),
    .wdata   (ctl_wdata),
    .flag_we (flag_we),
    .flag_in (flag_in),
    .ctl_q   (ctl_q)
  );

  always_comb begin
    st_d      = st_q;
    resv_set  = 1'b0;
    resv_clr  = 1'b0;
    flag_we   = 1'b0;
    flag_in   = 1'b0;
    fin       = 1'b0;
    fin_exc   = 1'b0;
    fin_cause = CAUSE_NONE;
    fin_rdata = '0;
    cap       = 1'b0;
    unique case (st_q)
      S_IDLE: if (op_valid) begin
        unique case (kind_in)
          OP_LOADEX: begin
            if (misal) begin
              fin = 1'b1; fin_exc = 1'b1; fin_cause = CAUSE_ALIGN;
            end else if (perm != CAUSE_NONE) begin
              fin = 1'b1; fin_exc = 1'b1; fin_cause = perm;
            end else begin
              cap = 1'b1;
            end
          end
          OP_STOREEX: begin
            if (misal) begin
              fin = 1'b1; fin_exc = 1'b1; fin_cause = CAUSE_ALIGN;
            end else if (!resv_hit) begin
              fin = 1'b1; flag_we = 1'b1; flag_in = 1'b0;
              fin_rdata = DW'(flag_now);
            end else if (perm != CAUSE_NONE) begin
              fin = 1'b1; fin_exc = 1'b1; fin_cause = perm;
            end else begin
              cap = 1'b1;
            end
          end
          OP_CLEAR: begin
            fin = 1'b1; resv_clr = 1'b1;
          end
          default: begin
            fin = 1'b1; flag_we = 1'b1; flag_in = op_wdata[0];
            fin_rdata = DW'(flag_now);
          end
        endcase
        if (cap) st_d = S_MEM;
      end
      S_MEM: if (mem_ready) begin
        fin = 1'b1;
        if (kind_q == OP_LOADEX) begin
          resv_set  = 1'b1;
          fin_rdata = mem_rdata;
        end else begin
          flag_we   = 1'b1;
          flag_in   = cas_pass;
          resv_clr  = 1'b1;
          fin_rdata = DW'(flag_now);
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (fin) st_d = S_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      kind_q  <= OP_LOADEX;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      exc_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
      rdata_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      if (cap) begin
        kind_q  <= kind_in;
        addr_q  <= op_addr;
        wdata_q <= op_wdata;
      end
      if (fin) begin
        exc_q   <= fin_exc;
        cause_q <= fin_cause;
        rdata_q <= fin_rdata;
      end
    end
  end

  assign op_done   = done_q;
  assign op_rdata  = rdata_q;
  assign op_exc    = exc_q;
  assign op_cause  = cause_q;
  assign mem_req   = (st_q == S_MEM);
  assign mem_cas   = (kind_q == OP_STOREEX);
  assign mem_addr  = addr_q;
  assign mem_cmp   = resv_val;
  assign mem_wdata = wdata_q;

  p_req_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr) && $stable(mem_cas)
                                 && $stable(mem_wdata) && $stable(mem_cmp))
    else $error("memory request changed before acknowledge");

  p_req_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(accept) && !$past(misal))
    else $error("memory request without an aligned accepted op");

  p_resv_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cas_ack |=> resv_addr == '1)
    else $error("reservation survived a matched store");

  p_flag_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_ack && !ctl_we) |=> ctl_q[FLAG_BIT] == ($past(mem_rdata) == $past(mem_cmp)))
    else $error("status flag does not match swap result");

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done)
    else $error("completion longer than one cycle");

  p_exc_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && op_exc) |-> !mem_req)
    else $error("exception with memory request");
endmodule

// File: tb/excl_monitor_test.sv
`timescale 1ns/1ps
module excl_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [8:0]  ctl_wdata = '0;
  logic        op_valid = 1'b0, nc_valid = 1'b0;
  logic [1:0]  op_kind = '0, op_attr = '0;
  logic [31:0] op_addr = '0, op_wdata = '0;
  logic        op_done, op_exc, mem_req, mem_cas;
  logic [31:0] op_rdata, mem_addr, mem_cmp, mem_wdata;
  logic [1:0]  op_cause;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic        nc_done, nc_exc, nc_req, nc_cas;
  logic [31:0] nc_rdata, nc_maddr, nc_cmp, nc_mw;
  logic [1:0]  nc_cause;

  logic [31:0] mem [0:15];
  logic        poke_en = 1'b0;
  logic [3:0]  poke_a = '0;
  logic [31:0] poke_d = '0;

  int checks = 0, failures = 0, txns = 0, cyc = 0;
  logic [31:0] r_data;
  logic        r_exc;
  logic [1:0]  r_cause;

  always #2.5 clk = ~clk;

  excl_monitor uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr), .op_wdata(op_wdata),
    .op_attr(op_attr), .op_done(op_done), .op_rdata(op_rdata), .op_exc(op_exc),
    .op_cause(op_cause), .mem_req(mem_req), .mem_cas(mem_cas), .mem_addr(mem_addr),
    .mem_cmp(mem_cmp), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  excl_monitor #(.HAS_DCACHE(1'b0)) uut_nc (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .op_valid(nc_valid), .op_kind(op_kind), .op_addr(op_addr), .op_wdata(op_wdata),
    .op_attr(op_attr), .op_done(nc_done), .op_rdata(nc_rdata), .op_exc(nc_exc),
    .op_cause(nc_cause), .mem_req(nc_req), .mem_cas(nc_cas), .mem_addr(nc_maddr),
    .mem_cmp(nc_cmp), .mem_wdata(nc_mw), .mem_ready(1'b0), .mem_rdata(32'h0)
  );

  // Memory model: one-cycle acknowledge, swap done in a single step.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'h100 + i;
      mem_ready <= 1'b0;
    end else if (poke_en) begin
      mem[poke_a] <= poke_d;
    end else if (mem_req && !mem_ready) begin
      mem_ready <= 1'b1;
      mem_rdata <= mem[mem_addr[5:2]];
      if (mem_cas && mem[mem_addr[5:2]] == mem_cmp) mem[mem_addr[5:2]] <= mem_wdata;
    end else begin
      mem_ready <= 1'b0;
    end
  end

  always @(posedge clk) if (rst_n && mem_req && mem_ready) txns++;

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not finish");
      report();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [8:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic poke(input int idx, input logic [31:0] v);
    @(negedge clk); poke_en = 1'b1; poke_a = idx[3:0]; poke_d = v;
    @(negedge clk); poke_en = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] k, input logic [31:0] a, input logic [31:0] w,
                       input logic [1:0] at, input bit nc);
    int n = 0;
    @(negedge clk);
    op_kind = k; op_addr = a; op_wdata = w; op_attr = at;
    if (nc) nc_valid = 1'b1; else op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0; nc_valid = 1'b0;
    while (!(nc ? nc_done : op_done) && n < 100) begin
      @(negedge clk); n++;
    end
    r_data  = nc ? nc_rdata : op_rdata;
    r_exc   = nc ? nc_exc : op_exc;
    r_cause = nc ? nc_cause : op_cause;
  endtask

  function automatic logic [1:0] exp_cause(input logic [8:0] c, input int attr, input bit nc);
    int sel = nc ? 0 : attr;
    if (sel == 3) return 2'd2;
    return (((c >> (2 * sel)) & 9'h3) == 0) ? 2'd3 : 2'd0;
  endfunction

  initial begin
    int t0;
    logic [8:0] cv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    t0 = txns;
    do_op(2'd3, 0, 0, 0, 0);
    check("R1 flag after reset", r_data, 0);
    do_op(2'd1, 32'h8, 32'hAA, 0, 0);
    check("R1 store fails with no reservation", {r_exc, 31'(txns - t0)}, 0);
    check("R1 memory untouched", mem[2], 32'h102);
    do_op(2'd0, 32'h0, 0, 0, 0); // reset control 0x028 has bypass field 0
    check("R1 reset control denies bypass", {30'd0, r_cause}, 3);

    // R14 + R12: control 0x29, documented sequence
    set_ctl(9'h029);
    poke(1, 32'd3);
    do_op(2'd2, 0, 0, 2, 0);
    t0 = txns;
    do_op(2'd1, 32'h4, 32'd1, 2, 0);
    check("R3 mismatch no memory request", txns - t0, 0);
    do_op(2'd3, 0, 0, 2, 0);
    check("R12 status 0 after unreserved store", r_data, 0);
    check("R12 word still 3", mem[1], 3);
    do_op(2'd0, 32'h4, 0, 2, 0);
    check("R2 load returns word", r_data, 3);
    t0 = txns;
    do_op(2'd1, 32'h4, 32'd2, 2, 0);
    check("R6 store returns previous flag", r_data, 0);
    check("R4 one swap issued", txns - t0, 1);
    do_op(2'd3, 0, 0, 2, 0);
    check("R12 status 1 after reserved store", r_data, 1);
    check("R12 word now 2", mem[1], 2);

    // R5: reservation gone after success
    t0 = txns;
    do_op(2'd1, 32'h4, 32'd9, 2, 0);
    check("R5 second store no request", txns - t0, 0);
    check("R5 word unchanged", mem[1], 2);

    // R4: other agent writes between load and store
    do_op(2'd0, 32'h8, 0, 2, 0);
    check("R2 load second word", r_data, 32'h102);
    poke(2, 32'h66);
    t0 = txns;
    do_op(2'd1, 32'h8, 32'h77, 2, 0);
    check("R4 swap issued on match", txns - t0, 1);
    check("R4 failed swap keeps other write", mem[2], 32'h66);
    do_op(2'd3, 0, 0, 2, 0);
    check("R6 flag 0 after failed swap", r_data, 0);
    t0 = txns;
    do_op(2'd1, 32'h8, 32'h77, 2, 0);
    check("R5 reservation dropped after failure", txns - t0, 0);

    // R7: swap status
    do_op(2'd3, 0, 32'h1, 0, 0);
    check("R7 returns old flag", r_data, 0);
    do_op(2'd3, 0, 32'hFFFF_FFFE, 0, 0);
    check("R7 returns flag set by previous swap", r_data, 1);
    do_op(2'd3, 0, 32'h1, 0, 0);
    do_op(2'd1, 32'h20, 0, 2, 0);
    check("R6 mismatch returns previous flag 1", r_data, 1);
    do_op(2'd3, 0, 0, 0, 0);
    check("R3 mismatch sets flag 0", r_data, 0);

    // R10: misalignment leaves state intact
    do_op(2'd0, 32'hC, 0, 2, 0);
    t0 = txns;
    for (int off = 1; off < 4; off++) begin
      do_op(2'd0, 32'hC + off, 0, 2, 0);
      check("R10 misaligned load cause", {r_exc, 29'd0, r_cause}, {1'b1, 29'd0, 2'd1});
      do_op(2'd1, 32'hC + off, 0, 2, 0);
      check("R10 misaligned store cause", {30'd0, r_cause}, 1);
    end
    check("R10 no memory traffic", txns - t0, 0);
    set_ctl(9'h019); // write-back field now 1, write-through 2, bypass 1... WB=01
    set_ctl(9'h009); // WB field 0 -> deny
    do_op(2'd1, 32'hC, 32'h5, 2, 0);
    check("R8 denied store on hit", {30'd0, r_cause}, 3);
    set_ctl(9'h029);
    t0 = txns;
    do_op(2'd1, 32'hC, 32'h5, 2, 0);
    check("R10 reservation kept through exceptions", txns - t0, 1);
    check("R10 store after exceptions lands", mem[3], 5);

    // R8 / R9: permission sweep
    for (int at = 0; at < 4; at++) begin
      for (int fv = 0; fv < 4; fv++) begin
        cv = (at == 3) ? 9'h03F : 9'(fv << (2 * at));
        set_ctl(cv);
        t0 = txns;
        do_op(2'd0, 32'h10, 0, at[1:0], 0);
        check(at == 3 ? "R9 isolate cause" : "R8 field cause", {30'd0, r_cause},
              {30'd0, exp_cause(cv, at, 0)});
        check("R8 request only when allowed", txns - t0,
              (exp_cause(cv, at, 0) == 0) ? 1 : 0);
        if (exp_cause(cv, at, 0) == 0) check("R2 sweep load data", r_data, 32'h104);
      end
    end
    set_ctl(9'h03C);
    for (int at = 0; at < 4; at++) begin
      do_op(2'd0, 32'h10, 0, at[1:0], 1);
      check("R9 no-cache uses bypass field", {30'd0, r_cause}, {30'd0, exp_cause(9'h03C, at, 1)});
    end

    // R11: clear
    set_ctl(9'h029);
    do_op(2'd0, 32'h14, 0, 0, 0);
    do_op(2'd2, 0, 0, 0, 0);
    t0 = txns;
    do_op(2'd1, 32'h14, 32'h1, 0, 0);
    check("R11 store after clear no request", txns - t0, 0);
    check("R11 word unchanged", mem[5], 32'h105);

    report();
  end
endmodule